// File: doc/BRIEF.md
# Masked Change-Detect Interrupt Generator

This block watches a parallel input port and pulls an active-low, open-drain interrupt line low when a watched input no longer matches the value last recorded for it. A status register records the port when the chip select falls. That capture also clears any pending request, because the recorded and live values then match. A mask register is loaded from the `mask_val` bus when the chip select rises. Each mask bit set to 1 arms the change detector for that input. A mask bit of 0 silences that input.

An external enable, `gate_en`, powers the port. While it is low, the interrupt line is released to high impedance. The port value seen by the block is also frozen at the last value it had while enabled, so a capture during that time records the frozen value and not the live pins. The live pins pass through a multi-flop synchronizer before any comparison. Since the output only ever pulls low or floats, several instances can share one pulled-up line as a wired-AND.

Top module: `chgdet_irq`

## Requirements
- R1: With `gate_en` high, `irq_drive_low` is 1 exactly when some bit of the synchronized port differs from `status_q` and the mask bit for that position is 1. It is 0 otherwise.
- R2: An input whose mask bit is 0 never causes `irq_drive_low` to go high, whatever its value. Mask bit n guards port bit n.
- R3: After a synchronous reset (`rst_n` low at a rising clock edge), `status_q` and the mask are all zeros, and `irq_drive_low` stays 0 whatever the port does until a mask is loaded.
- R4: At a rising clock edge where `cs_n` was 1 at the previous edge and is 0 now, `status_q` takes the port value the block currently sees. From that edge on, with the port unchanged, `irq_drive_low` is 0.
- R5: At a rising clock edge where `cs_n` was 0 at the previous edge and is 1 now, the mask takes `mask_val`. At any other edge the mask keeps its value, so changes on `mask_val` outside that edge have no effect.
- R6: While `gate_en` is 0, `irq_hiz` is 1 and `irq_drive_low` is 0, without waiting for a clock edge.
- R7: While `gate_en` is 0, the port value seen by the block stays at the synchronized value from the last clock edge at which `gate_en` was 1. A capture in that time records this held value.
- R8: A change on `pin_in` reaches the comparison after two rising clock edges (the default synchronizer depth). After only one edge, `irq_drive_low` still reflects the old value.
- R9: `irq_drive_low` and `irq_hiz` are never 1 at the same time, so the line is either pulled low or released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_in | input | WIDTH | Monitored input port, asynchronous to `clk` |
| gate_en | input | 1 | Port and interrupt enable, active high |
| cs_n | input | 1 | Chip select: falling edge captures status, rising edge loads the mask |
| mask_val | input | WIDTH | Mask value loaded when `cs_n` rises |
| status_q | output | WIDTH | Captured input status register |
| irq_drive_low | output | 1 | When 1, the interrupt line is pulled low |
| irq_hiz | output | 1 | When 1, the interrupt line is released to high impedance |

## Verification
The hardest state to reach from the ports is a capture taken while the port is disabled and the live pins have already moved. It must record the held value and not the live one. The stimulus records a known pattern, drops `gate_en`, inverts every pin, lets the synchronizer settle, and then runs a chip-select cycle. It then re-enables and checks that the inverted pins raise the request at once and that a second capture records them. A full sweep writes each one-hot mask in turn and flips every port bit against it, so each mask-to-input pairing is exercised.

// File: rtl/chgdet_pkg.sv
// Package: shared types for the change-detect interrupt generator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package chgdet_pkg;

    // Default geometry of the monitored port and its synchronizer.
    localparam int DEF_WIDTH = 16;
    localparam int DEF_SYNC  = 2;

    // Chip-select event decoded from the previous and current samples.
    typedef enum logic [1:0] {
        CS_IDLE = 2'b00,  // deselected, steady high
        CS_FALL = 2'b01,  // high -> low: capture status
        CS_RISE = 2'b10,  // low -> high: load mask
        CS_BUSY = 2'b11   // selected, steady low
    } cs_evt_e;

    // Decode one chip-select event from the registered and current levels.
    function automatic cs_evt_e cs_decode(input logic prev_lvl, input logic cur_lvl);
        cs_evt_e e;
        case ({prev_lvl, cur_lvl})
            2'b10:   e = CS_FALL;
            2'b01:   e = CS_RISE;
            2'b00:   e = CS_BUSY;
            default: e = CS_IDLE;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/chgdet_sync.sv
// Module: chgdet_sync
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes STAGES >= 1; every stage clears on a synchronous active-low reset.
module chgdet_sync #(
    parameter int W      = chgdet_pkg::DEF_WIDTH,
    parameter int STAGES = chgdet_pkg::DEF_SYNC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the raw asynchronous port.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                // Later stages retime the previous stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[LAST];

endmodule

// File: rtl/chgdet_hold.sv
// Module: chgdet_hold
// Gates the synchronized port with the enable. While enabled, the output
// follows the input and a hold register tracks it. While disabled, the
// output is the value held from the last enabled clock edge.
// Assumes gate_en is a level that the interrupt path may use directly.
module chgdet_hold #(
    parameter int W = chgdet_pkg::DEF_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         gate_en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] held_q;

    // Track the synchronized port on every enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       held_q <= '0;
        else if (gate_en) held_q <= d;
    end

    // Select the live port while enabled and the held value otherwise.
    always_comb begin
        q = gate_en ? d : held_q;
    end

endmodule

// File: rtl/chgdet_capture.sv
// Module: chgdet_capture
// Owns the status and mask registers. A falling chip select records the
// effective port into status. A rising chip select loads the mask.
// Assumes cs_n is synchronous to clk. The previous-level register is not
// reset, so edge decoding matches the sampled levels.
module chgdet_capture
    import chgdet_pkg::*;
#(
    parameter int W = DEF_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic [W-1:0] eff_in,
    input  logic [W-1:0] mask_val,
    output logic [W-1:0] status_q,
    output logic [W-1:0] mask_q
);
    logic    cs_prev;
    cs_evt_e evt;

    // Remember the chip-select level of the previous edge.
    always_ff @(posedge clk) begin
        cs_prev <= cs_n;
    end

    // Classify the current chip-select event.
    always_comb begin
        evt = cs_decode(cs_prev, cs_n);
    end

    // Record the effective port when select falls.
    always_ff @(posedge clk) begin
        if (!rst_n)               status_q <= '0;
        else if (evt == CS_FALL)  status_q <= eff_in;
    end

    // Load the mask when select rises.
    always_ff @(posedge clk) begin
        if (!rst_n)               mask_q <= '0;
        else if (evt == CS_RISE)  mask_q <= mask_val;
    end

endmodule

// File: rtl/chgdet_irq.sv
// Module: chgdet_irq (top)
// Masked change-detect interrupt generator with an open-drain style output:
// irq_drive_low pulls the line low, and irq_hiz releases it.
// Assumes clk-synchronous rst_n and cs_n. pin_in may be asynchronous.
module chgdet_irq
    import chgdet_pkg::*;
#(
    parameter int WIDTH       = DEF_WIDTH,
    parameter int SYNC_STAGES = DEF_SYNC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    input  logic             gate_en,
    input  logic             cs_n,
    input  logic [WIDTH-1:0] mask_val,
    output logic [WIDTH-1:0] status_q,
    output logic             irq_drive_low,
    output logic             irq_hiz
);
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] eff_in;
    logic [WIDTH-1:0] mask_q;
    logic [WIDTH-1:0] armed_diff;

    chgdet_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    chgdet_hold #(.W(WIDTH)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate_en (gate_en),
        .d       (pin_sync),
        .q       (eff_in)
    );

    chgdet_capture #(.W(WIDTH)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .eff_in   (eff_in),
        .mask_val (mask_val),
        .status_q (status_q),
        .mask_q   (mask_q)
    );

    // Compare the effective port with status, keeping armed bits only.
    always_comb begin
        armed_diff = (eff_in ^ status_q) & mask_q;
    end

    // Drive the line low on any armed mismatch, and release it when disabled.
    always_comb begin
        irq_drive_low = gate_en & (|armed_diff);
        irq_hiz       = ~gate_en;
    end

endmodule

// File: rtl/chgdet_irq_chk.sv
// Module: chgdet_irq_chk
// Property checker bound into chgdet_irq.
module chgdet_irq_chk #(
    parameter int WIDTH = chgdet_pkg::DEF_WIDTH
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gate_en,
    input logic             cs_n,
    input logic [WIDTH-1:0] mask_val,
    input logic [WIDTH-1:0] status_q,
    input logic [WIDTH-1:0] eff_in,
    input logic [WIDTH-1:0] mask_q,
    input logic             irq_drive_low,
    input logic             irq_hiz
);
    AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_drive_low);                           // R2

    AST_RESET_CLEARS: assert property (@(posedge clk)
        (rst_n && $past(!rst_n)) |-> (status_q == '0 && mask_q == '0)); // R3

    AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |=> (status_q == $past(eff_in)));                 // R4

    AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> (mask_q == $past(mask_val)));                 // R5

    AST_MASK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(cs_n) |=> $stable(mask_q));                            // R5

    AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |-> (irq_hiz && !irq_drive_low));                    // R6

    AST_OFF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_en && $past(!gate_en)) |-> $stable(eff_in));           // R7

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_hiz && irq_drive_low));                                 // R9

endmodule

bind chgdet_irq chgdet_irq_chk #(.WIDTH(WIDTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .gate_en       (gate_en),
    .cs_n          (cs_n),
    .mask_val      (mask_val),
    .status_q      (status_q),
    .eff_in        (eff_in),
    .mask_q        (mask_q),
    .irq_drive_low (irq_drive_low),
    .irq_hiz       (irq_hiz)
);

// File: tb/sim_chgdet_irq.sv
`timescale 1ns/1ps
// Bench for chgdet_irq: sweeps single-bit changes and one-hot masks on the
// default 16-bit configuration, with expected values computed here.
module sim_chgdet_irq;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] pin_in = '0;
    logic         gate_en = 1'b1;
    logic         cs_n = 1'b1;
    logic [W-1:0] mask_val = '0;
    logic [W-1:0] status_q;
    logic         irq_drive_low;
    logic         irq_hiz;

    int unsigned total = 0;
    int unsigned bad   = 0;

    chgdet_irq u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .pin_in        (pin_in),
        .gate_en       (gate_en),
        .cs_n          (cs_n),
        .mask_val      (mask_val),
        .status_q      (status_q),
        .irq_drive_low (irq_drive_low),
        .irq_hiz       (irq_hiz)
    );

    always #4 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One chip-select cycle: status captured on the falling edge, mask loaded on the rising edge.
    task automatic txn(input logic [W-1:0] newmask, input logic [W-1:0] exp_status, input string req);
        cs_n = 1'b0;
        tick(1);
        chk(status_q, exp_status, req);
        chk({15'd0, irq_drive_low}, 16'd0, req);
        cs_n = 1'b1;
        mask_val = newmask;
        tick(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [W-1:0] pv;
        logic [W-1:0] held;
        pv = 16'hA5A5;
        pin_in = pv;
        mask_val = 16'hFFFF;
        tick(3);
        rst_n = 1'b1;
        tick(3);
        // R3: reset state, and no interrupt with a zero mask
        chk(status_q, 16'h0000, "R3 status");
        chk({15'd0, irq_drive_low}, 16'd0, "R3 irq");
        chk({15'd0, irq_hiz}, 16'd0, "R6 enabled");
        // R5: mask_val moves while select stays high, so the mask stays zero
        tick(4);
        chk({15'd0, irq_drive_low}, 16'd0, "R5 mask untouched");

        // Arm every bit, recording the current port
        txn(16'hFFFF, pv, "R4 first capture");
        mask_val = 16'h0000;  // R5: ignored while select is high
        tick(2);
        chk({15'd0, irq_drive_low}, 16'd0, "R4 matched after capture");

        // R1/R8/R4: flip each bit, watch latency, then recapture
        for (int i = 0; i < W; i++) begin
            pv[i] = ~pv[i];
            pin_in = pv;
            tick(1);
            chk({15'd0, irq_drive_low}, 16'd0, "R8 one edge");
            tick(1);
            chk({15'd0, irq_drive_low}, 16'd1, "R1 change seen");
            txn(16'hFFFF, pv, "R4 recapture");
        end

        // R2: every one-hot mask against every one-bit change
        for (int i = 0; i < W; i++) begin
            txn(16'h0001 << i, pv, "R4 sweep capture");
            for (int j = 0; j < W; j++) begin
                pin_in = pv ^ (16'h0001 << j);
                tick(2);
                chk({15'd0, irq_drive_low}, {15'd0, (i == j)}, "R2 mask sweep");
                pin_in = pv;
                tick(2);
                chk({15'd0, irq_drive_low}, 16'd0, "R2 restored");
            end
        end

        // R6/R7: disable, move the pins, capture the held value, re-enable
        pv = 16'h1234;
        pin_in = pv;
        tick(3);
        txn(16'hFFFF, pv, "R4 pre-disable");
        held = pv;
        gate_en = 1'b0;
        #1;
        chk({15'd0, irq_hiz}, 16'd1, "R6 hiz immediate");
        chk({15'd0, irq_drive_low}, 16'd0, "R6 no drive");
        pv = ~pv;
        pin_in = pv;
        tick(3);
        chk({15'd0, irq_hiz}, 16'd1, "R6 hiz held");
        chk({15'd0, irq_drive_low}, 16'd0, "R6 mismatch ignored");
        txn(16'hFFFF, held, "R7 capture returns held");
        gate_en = 1'b1;
        #1;
        chk({15'd0, irq_hiz}, 16'd0, "R6 released");
        chk({15'd0, irq_drive_low}, 16'd1, "R1 live after enable");
        tick(1);
        txn(16'hFFFF, pv, "R7 live capture");
        tick(1);
        chk({15'd0, irq_drive_low}, 16'd0, "R1 cleared");

        // R3: a fresh reset clears status and mask
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        pin_in = 16'hFFFF;
        tick(3);
        chk(status_q, 16'h0000, "R3 second reset");
        chk({15'd0, irq_drive_low}, 16'd0, "R3 quiet after reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule